// File: doc/BRIEF.md
# Inline Exception Handler Admission Gate

This block sits beside the front end of an out-of-order core and decides, for each exception, whether a short handler of known length may be threaded into the running user instruction stream or whether the core must take the classic full flush. With each request it receives the handler's instruction count. It compares that count against the number of free reorder-buffer slots, free reservation-station slots and free physical registers. Only when all three can hold the whole handler is it admitted. The purpose is to avoid the live-lock that arises when the handler is started but cannot fit into a nearly full reorder buffer.

An admitted handler is steered into fetch one instruction at a time. Fetch reports each issued handler instruction. The block numbers these instructions in program order and tags each one as privileged, while everything else stays unprivileged. It marks the final handler instruction, the return from exception, so that fetch replaces it with a NOP. It then pulses a replay request so that the faulting user instruction is executed again. An exception that arrives while a handler is still being injected, or in the replay cycle, always takes the flush path and abandons the injection.

The state machine has three states. ST_IDLE waits for a request. ST_INJECT steers fetch into the handler. ST_REPLAY lasts one cycle and signals that the faulting instruction is to be re-run. Its transitions are:
- admit: ST_IDLE to ST_INJECT, on an admitted request.
- finish: ST_INJECT to ST_REPLAY, on the issue of the last handler instruction.
- abort: ST_INJECT to ST_IDLE, on a new exception.
- done: ST_REPLAY to ST_IDLE, unconditionally.

A rejected request in ST_IDLE leaves the state unchanged.

Top module: `handler_inline_gate`

## Requirements
- R1: After reset, inline_go, flush_req, replay_go, inst_priv and ret_nop are 0 and inj_idx is 0.
- R2: A request seen in ST_IDLE with a nonzero length is admitted when free_rob, free_rs and free_reg are each at least the length. Admission shows as a one-cycle inline_go pulse in the cycle after the request.
- R3: Every other request produces a one-cycle flush_req pulse in the cycle after the request. This includes a zero length and any single resource falling short.
- R4: For each request exactly one of inline_go and flush_req pulses, never both at once.
- R5: inst_priv is 1 in every cycle of ST_INJECT, which tags the instruction fetch is taking as privileged. It is 0 in all other cycles, which tags user instructions as unprivileged.
- R6: inj_idx starts at 0 after admission and advances by one for each cycle with inj_issue high in ST_INJECT. It returns to 0 once the last handler instruction has issued.
- R7: ret_nop is 1 exactly when inst_priv is 1 and inj_idx equals the handler length minus one. This marks the return instruction for conversion to a NOP.
- R8: replay_go pulses for one cycle in the cycle after the last handler instruction issues. The following cycle is back in ST_IDLE.
- R9: A request while in ST_INJECT or ST_REPLAY gives flush_req and never inline_go. The injection is abandoned, so inst_priv is 0 and inj_idx is 0 in the next cycle.
- R10: Free counts exactly equal to the length are enough for admission.
- R11: inj_issue outside ST_INJECT is ignored: inj_idx stays 0 and ret_nop stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_len | input | LEN_W (6) | Handler instruction count |
| free_rob | input | CNT_W (7) | Free reorder-buffer entries |
| free_rs | input | CNT_W (7) | Free reservation-station entries |
| free_reg | input | CNT_W (7) | Free physical registers |
| inj_issue | input | 1 | Fetch issued one handler instruction this cycle |
| inline_go | output | 1 | Pulse: handler admitted for inline injection |
| flush_req | output | 1 | Pulse: full pipeline flush requested |
| inst_priv | output | 1 | Privilege tag of the instruction fetch is taking now |
| inj_idx | output | LEN_W (6) | Program-order index of the handler instruction being injected |
| ret_nop | output | 1 | Current handler instruction is the return; issue it as NOP |
| replay_go | output | 1 | Pulse: re-execute the faulting instruction |

## Verification
The assertions assume that exc_valid is a single-cycle strobe per exception. They also assume that the free counts and the length are stable in the cycle the request is sampled, and that fetch raises inj_issue at most once per cycle. The stimulus drives every input on the falling edge, holds exc_valid for exactly one cycle and only changes the free counts alongside it. It issues handler instructions one per cycle, so that admission, numbering and the abort path are each exercised within these limits.

// File: rtl/hig_pkg.sv
package hig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INJECT = 2'd1,
        ST_REPLAY = 2'd2
    } hig_state_e;

    localparam int unsigned NUM_RES = 3;
endpackage

// File: rtl/hig_admit.sv
module hig_admit #(
    parameter int unsigned LEN_W = 6,
    parameter int unsigned CNT_W = 7,
    parameter int unsigned NRES  = 3
) (
    input  logic [LEN_W-1:0]           need,
    input  logic [NRES-1:0][CNT_W-1:0] free_cnt,
    output logic                       fits
);
    localparam int unsigned PAD = CNT_W - LEN_W;

    logic [CNT_W-1:0] need_ext;
    logic [NRES-1:0]  res_ok;

    assign need_ext = {{PAD{1'b0}}, need};

    for (genvar g = 0; g < NRES; g++) begin : g_res
        assign res_ok[g] = (free_cnt[g] >= need_ext);
    end

    // a zero-length handler is not a handler: force the flush path
    assign fits = (&res_ok) && (need != '0);
endmodule

// File: rtl/hig_counter.sv
module hig_counter #(
    parameter int unsigned LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt,
    output logic             at_last
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            len_q <= len;
            cnt   <= '0;
        end else if (clr) begin
            cnt   <= '0;
        end else if (inc) begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == len_q - 1'b1);
endmodule

// File: rtl/handler_inline_gate.sv
module handler_inline_gate
    import hig_pkg::*;
#(
    parameter int unsigned LEN_W = 6,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_valid,
    input  logic [LEN_W-1:0] exc_len,
    input  logic [CNT_W-1:0] free_rob,
    input  logic [CNT_W-1:0] free_rs,
    input  logic [CNT_W-1:0] free_reg,
    input  logic             inj_issue,
    output logic             inline_go,
    output logic             flush_req,
    output logic             inst_priv,
    output logic [LEN_W-1:0] inj_idx,
    output logic             ret_nop,
    output logic             replay_go
);
    hig_state_e state_q, state_d;

    logic                             fits;
    logic                             at_last;
    logic                             take_inline;
    logic                             take_flush;
    logic                             injecting;
    logic                             last_issue;
    logic [NUM_RES-1:0][CNT_W-1:0]    free_vec;

    assign free_vec = {free_reg, free_rs, free_rob};

    hig_admit #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .NRES  (NUM_RES)
    ) u_admit (
        .need     (exc_len),
        .free_cnt (free_vec),
        .fits     (fits)
    );

    assign injecting   = (state_q == ST_INJECT);
    assign take_inline = exc_valid && (state_q == ST_IDLE) && fits;
    assign take_flush  = exc_valid && !take_inline;
    assign last_issue  = injecting && inj_issue && at_last && !exc_valid;

    hig_counter #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_inline),
        .len     (exc_len),
        .clr     (!injecting || last_issue || exc_valid),
        .inc     (injecting && inj_issue && !exc_valid),
        .cnt     (inj_idx),
        .at_last (at_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_inline) state_d = ST_INJECT;
            end
            ST_INJECT: begin
                if (exc_valid)       state_d = ST_IDLE;
                else if (last_issue) state_d = ST_REPLAY;
            end
            ST_REPLAY: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inline_go <= 1'b0;
            flush_req <= 1'b0;
            replay_go <= 1'b0;
        end else begin
            inline_go <= take_inline;
            flush_req <= take_flush;
            replay_go <= last_issue;
        end
    end

    assign inst_priv = injecting;
    assign ret_nop   = injecting && at_last;
endmodule

// File: rtl/hig_checker.sv
module hig_checker #(
    parameter int unsigned LEN_W = 6,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_valid,
    input logic [LEN_W-1:0] exc_len,
    input logic [CNT_W-1:0] free_rob,
    input logic [CNT_W-1:0] free_rs,
    input logic [CNT_W-1:0] free_reg,
    input logic             inj_issue,
    input logic             inline_go,
    input logic             flush_req,
    input logic             inst_priv,
    input logic [LEN_W-1:0] inj_idx,
    input logic             ret_nop,
    input logic             replay_go
);
    // R4
    one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inline_go && flush_req));

    // R2
    admit_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inline_go |-> ($past(exc_len) != '0)
                   && ($past(free_rob) >= CNT_W'($past(exc_len)))
                   && ($past(free_rs)  >= CNT_W'($past(exc_len)))
                   && ($past(free_reg) >= CNT_W'($past(exc_len))));

    // R5
    admit_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inline_go |-> inst_priv && (inj_idx == '0));

    // R7
    nop_in_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_nop |-> inst_priv);

    // R9
    nested_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && (inst_priv || replay_go)) |=> flush_req && !inline_go && !inst_priv);

    // R8
    replay_after_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_go |-> $past(ret_nop && inj_issue) && !inst_priv);

    // R11
    idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_priv |-> (inj_idx == '0) && !ret_nop);
endmodule

bind handler_inline_gate hig_checker #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
) u_hig_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_valid (exc_valid),
    .exc_len   (exc_len),
    .free_rob  (free_rob),
    .free_rs   (free_rs),
    .free_reg  (free_reg),
    .inj_issue (inj_issue),
    .inline_go (inline_go),
    .flush_req (flush_req),
    .inst_priv (inst_priv),
    .inj_idx   (inj_idx),
    .ret_nop   (ret_nop),
    .replay_go (replay_go)
);

// File: tb/tb_handler_inline_gate.sv
module tb_handler_inline_gate;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 6;
    localparam int CNT_W = 7;
    localparam int NVEC  = 9;

    // {expect_inline, len, rob, rs, reg}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 6'd10, 7'd10,  7'd10,  7'd10 },
        {1'b1, 6'd30, 7'd64,  7'd64,  7'd64 },
        {1'b0, 6'd30, 7'd29,  7'd64,  7'd64 },
        {1'b0, 6'd12, 7'd64,  7'd11,  7'd64 },
        {1'b0, 6'd12, 7'd64,  7'd64,  7'd11 },
        {1'b0, 6'd0,  7'd64,  7'd64,  7'd64 },
        {1'b1, 6'd63, 7'd127, 7'd127, 7'd127},
        {1'b1, 6'd1,  7'd1,   7'd1,   7'd1  },
        {1'b0, 6'd20, 7'd0,   7'd0,   7'd0  }
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exc_valid = 1'b0;
    logic [LEN_W-1:0] exc_len = '0;
    logic [CNT_W-1:0] free_rob = '0;
    logic [CNT_W-1:0] free_rs = '0;
    logic [CNT_W-1:0] free_reg = '0;
    logic             inj_issue = 1'b0;
    logic             inline_go, flush_req, inst_priv, ret_nop, replay_go;
    logic [LEN_W-1:0] inj_idx;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    handler_inline_gate #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_len(exc_len),
        .free_rob(free_rob), .free_rs(free_rs), .free_reg(free_reg),
        .inj_issue(inj_issue), .inline_go(inline_go), .flush_req(flush_req),
        .inst_priv(inst_priv), .inj_idx(inj_idx), .ret_nop(ret_nop),
        .replay_go(replay_go)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one request; returns after the decision cycle, at a falling edge
    task automatic request(input int len, input int rob, input int rs, input int rg);
        @(negedge clk);
        exc_valid = 1'b1;
        exc_len   = LEN_W'(len);
        free_rob  = CNT_W'(rob);
        free_rs   = CNT_W'(rs);
        free_reg  = CNT_W'(rg);
        @(negedge clk);
        exc_valid = 1'b0;
    endtask

    // issue len handler instructions, checking tag, index and return marker
    task automatic run_handler(input int len);
        for (int i = 0; i < len; i++) begin
            inj_issue = 1'b1;
            #1;
            chk(inst_priv == 1'b1, "R5 priv during inject", int'(inst_priv), 1);
            chk(int'(inj_idx) == i, "R6 idx order", int'(inj_idx), i);
            chk(ret_nop == (i == len - 1), "R7 ret nop", int'(ret_nop), int'(i == len - 1));
            @(negedge clk);
        end
        inj_issue = 1'b0;
        #1;
        chk(replay_go == 1'b1, "R8 replay pulse", int'(replay_go), 1);
        chk(inst_priv == 1'b0, "R5 priv off in replay", int'(inst_priv), 0);
        chk(inj_idx == '0, "R6 idx back to zero", int'(inj_idx), 0);
        @(negedge clk);
        chk(replay_go == 1'b0, "R8 replay single", int'(replay_go), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!inline_go && !flush_req && !replay_go, "R1 pulses low", int'(inline_go|flush_req|replay_go), 0);
        chk(!inst_priv && !ret_nop && inj_idx == '0, "R1 tag/idx", int'(inst_priv|ret_nop)+int'(inj_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R10
        for (int v = 0; v < NVEC; v++) begin
            logic exp_in;
            int   len;
            exp_in = VEC[v][27];
            len    = int'(VEC[v][26:21]);
            request(len, int'(VEC[v][20:14]), int'(VEC[v][13:7]), int'(VEC[v][6:0]));
            chk(inline_go == exp_in, "R2 inline decision", int'(inline_go), int'(exp_in));
            chk(flush_req == !exp_in, "R3 flush decision", int'(flush_req), int'(!exp_in));
            chk(!(inline_go && flush_req), "R4 exclusive", int'(inline_go & flush_req), 0);
            if (exp_in) begin
                run_handler(len);
            end else begin
                @(negedge clk);
                chk(flush_req == 1'b0, "R3 flush single", int'(flush_req), 0);
                chk(inst_priv == 1'b0, "R5 no priv after flush", int'(inst_priv), 0);
            end
        end

        // R10: equality for one resource, others larger
        request(25, 25, 90, 90);
        chk(inline_go == 1'b1, "R10 equal admits", int'(inline_go), 1);
        run_handler(25);

        // R11: issue strobes while idle are ignored
        inj_issue = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(inj_idx == '0 && !ret_nop, "R11 idle issue ignored", int'(inj_idx), 0);
        end
        inj_issue = 1'b0;
        request(3, 64, 64, 64);
        chk(inj_idx == '0, "R11 idx starts at zero", int'(inj_idx), 0);
        run_handler(3);

        // R9: exception during injection
        request(20, 64, 64, 64);
        chk(inline_go == 1'b1, "R9 setup admit", int'(inline_go), 1);
        inj_issue = 1'b1;
        repeat (5) @(negedge clk);
        inj_issue = 1'b0;
        chk(int'(inj_idx) == 5, "R6 partial idx", int'(inj_idx), 5);
        request(10, 127, 127, 127);
        chk(flush_req == 1'b1 && inline_go == 1'b0, "R9 nested flush", int'(flush_req), 1);
        chk(inst_priv == 1'b0 && inj_idx == '0, "R9 abandoned", int'(inst_priv), 0);

        // R9: exception in the replay cycle
        request(1, 64, 64, 64);
        inj_issue = 1'b1;
        @(negedge clk);
        inj_issue = 1'b0;
        chk(replay_go == 1'b1, "R8 replay before nested", int'(replay_go), 1);
        exc_valid = 1'b1;
        exc_len   = 6'd5;
        @(negedge clk);
        exc_valid = 1'b0;
        chk(flush_req == 1'b1 && inline_go == 1'b0, "R9 replay flush", int'(flush_req), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule